// File: doc/BRIEF.md
# CAN Receive Status Flags

This block keeps the per-buffer receive status of a CAN controller that has sixteen message buffers. It holds two 16-bit flag vectors. The receive-complete vector records that a message has been stored into a buffer. The remote-request vector records that the last frame stored into a buffer was a remote frame. The message handler reports events as one-cycle pulses that carry a buffer index. Software reads the flags and clears them through a byte-wide register port.

Flags are write-zero-to-clear. A hardware set always wins over any clear that lands in the same cycle. The remote-request flag is also cleared by hardware when a data frame lands in the buffer, or when a transmission from the buffer completes. A read that belongs to a read-modify-write sequence returns all ones, so writing the value back cannot clear a pending flag. The receive interrupt is the OR of every receive-complete flag whose enable bit is set.

Top module: `can_rx_flags`

## Requirements
- R1: A pulse on `rx_done` with index `rx_buf` = x sets receive-complete flag x. The flag is visible from the clock edge that samples the pulse onward, whatever the frame type.
- R2: `rx_irq` is high exactly when some receive-complete flag x is 1 and `rx_irq_en[x]` is 1. It follows the mask combinationally and is low whenever the mask is all zero.
- R3: Writing a 0 to a flag bit clears it. Writing a 1 leaves the bit unchanged.
- R4: If a hardware set and a software write of 0 reach the same bit in the same cycle, the bit ends at 1.
- R5: A receive pulse with `rx_remote` = 1 for buffer x sets both remote-request flag x and receive-complete flag x in the same edge.
- R6: A receive pulse with `rx_remote` = 0 for buffer x clears remote-request flag x and sets receive-complete flag x in the same edge.
- R7: A pulse on `tx_done` with index `tx_buf` = x clears remote-request flag x. A remote-frame receive for the same buffer in the same cycle wins, and the flag ends at 1.
- R8: While `bus_sel` = 1, `bus_wr` = 0, `bus_rmw` = 1 and the address hits one of the four flag bytes, `bus_rdata` is 8'hFF. A normal read returns the true flag values.
- R9: After reset, every bit of both vectors is 0 and `rx_irq` is 0.
- R10: Byte address map with the default base 8'h48: 8'h48 holds receive-complete bits 7:0, 8'h49 holds bits 15:8, 8'h4A holds remote-request bits 7:0, and 8'h4B holds bits 15:8. Reads of any other address return 8'h00, and writes to any other address change nothing.
- R11: A byte write changes only the eight flags of the addressed byte. Flags in the other byte keep their value and still accept hardware sets in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_done | input | 1 | One-cycle pulse: a received frame has been stored |
| rx_buf | input | 4 | Buffer index of the stored frame |
| rx_remote | input | 1 | 1 = remote frame, 0 = data frame |
| tx_done | input | 1 | One-cycle pulse: a transmission has completed |
| tx_buf | input | 4 | Buffer index of the completed transmission |
| rx_irq_en | input | 16 | Per-buffer receive interrupt enable mask |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_rmw | input | 1 | Read belongs to a read-modify-write sequence |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that the message handler raises at most one receive pulse and at most one transmit pulse per cycle, each with a stable in-range index. They also assume that `bus_rmw` is only raised on reads. The bench drives every pulse for exactly one cycle on the falling edge and clears the bus strobe between accesses. It raises the read-modify-write flag only on reads. The same-cycle collisions it drives are receive against write and remote receive against transmit complete, which are the collisions the priority rules describe.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int NUM_BUF  = 16;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = $clog2(NUM_BUF);
  localparam int NUM_LANE = NUM_BUF / BYTE_W;

  // which flag vector a bus access targets
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RC   = 2'd1,
    REG_RT   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/can_rxf_dec.sv
module can_rxf_dec #(
  parameter int NB = 16,
  parameter int IW = 4
) (
  input  logic          valid_i,
  input  logic [IW-1:0] idx_i,
  output logic [NB-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    if (valid_i) vec_o[idx_i] = 1'b1;
  end
endmodule

// File: rtl/can_rxf_bank.sv
module can_rxf_bank #(
  parameter int NB    = 16,
  parameter int BW    = 8,
  parameter int LANES = NB / BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    set_i,
  input  logic [NB-1:0]    hclr_i,
  input  logic [LANES-1:0] wr_lane_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [NB-1:0]    flags_o
);
  logic [NB-1:0] swclr;

  // a written 0 clears, a written 1 is ignored
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign swclr[l*BW +: BW] = wr_lane_i[l] ? ~wdata_i : '0;
  end

  // set has priority over both hardware and software clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= set_i | (flags_o & ~hclr_i & ~swclr);
  end
endmodule

// File: rtl/can_rxf_regif.sv
module can_rxf_regif
  import can_rxf_pkg::*;
#(
  parameter int NB     = 16,
  parameter int BW     = 8,
  parameter int AW     = 8,
  parameter logic [AW-1:0] BASE = 8'h48,
  parameter int LANES  = NB / BW,
  parameter int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rmw_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BW-1:0]    unused_w_i,
  input  logic [NB-1:0]    rc_i,
  input  logic [NB-1:0]    rt_i,
  output logic [LANES-1:0] rc_lane_o,
  output logic [LANES-1:0] rt_lane_o,
  output logic [BW-1:0]    rdata_o
);
  localparam int BLK_W = LSEL_W + 1;
  localparam logic [AW-1:0] SPAN = AW'(2 * LANES);

  reg_sel_e          which;
  logic [LSEL_W-1:0] lane;
  logic [AW-1:0]     offs;
  logic              hit;
  logic [BW-1:0]     rc_b, rt_b;

  assign offs = addr_i - BASE;
  assign hit  = sel_i && (addr_i >= BASE) && (offs < SPAN);
  assign lane = offs[LSEL_W-1:0];

  always_comb begin
    which = REG_NONE;
    if (hit) which = offs[BLK_W-1] ? REG_RT : REG_RC;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_we
    assign rc_lane_o[l] = wr_i && (which == REG_RC) && (lane == LSEL_W'(l));
    assign rt_lane_o[l] = wr_i && (which == REG_RT) && (lane == LSEL_W'(l));
  end

  assign rc_b = rc_i[lane*BW +: BW];
  assign rt_b = rt_i[lane*BW +: BW];

  always_comb begin
    unique case (which)
      REG_RC:  rdata_o = rmw_i ? '1 : rc_b;
      REG_RT:  rdata_o = rmw_i ? '1 : rt_b;
      default: rdata_o = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^unused_w_i;
endmodule

// File: rtl/can_rx_flags.sv
module can_rx_flags
  import can_rxf_pkg::*;
#(
  parameter int NB = NUM_BUF,
  parameter int BW = BYTE_W,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h48,
  parameter int IW = $clog2(NB),
  parameter int LANES = NB / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done,
  input  logic [IW-1:0] rx_buf,
  input  logic          rx_remote,
  input  logic          tx_done,
  input  logic [IW-1:0] tx_buf,
  input  logic [NB-1:0] rx_irq_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rmw,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          rx_irq
);
  logic [NB-1:0]    rx_vec, tx_vec, rem_vec, dat_vec;
  logic [NB-1:0]    rc_q, rt_q;
  logic [LANES-1:0] rc_lane, rt_lane;

  can_rxf_dec #(.NB(NB), .IW(IW)) u_rx_dec (
    .valid_i(rx_done), .idx_i(rx_buf), .vec_o(rx_vec));
  can_rxf_dec #(.NB(NB), .IW(IW)) u_tx_dec (
    .valid_i(tx_done), .idx_i(tx_buf), .vec_o(tx_vec));

  assign rem_vec = rx_remote ? rx_vec : '0;
  assign dat_vec = rx_remote ? '0 : rx_vec;

  can_rxf_regif #(.NB(NB), .BW(BW), .AW(AW), .BASE(BASE)) u_regif (
    .sel_i(bus_sel), .wr_i(bus_wr), .rmw_i(bus_rmw), .addr_i(bus_addr),
    .unused_w_i(bus_wdata), .rc_i(rc_q), .rt_i(rt_q),
    .rc_lane_o(rc_lane), .rt_lane_o(rt_lane), .rdata_o(bus_rdata));

  can_rxf_bank #(.NB(NB), .BW(BW)) u_rc_bank (
    .clk(clk), .rst_n(rst_n), .set_i(rx_vec), .hclr_i('0),
    .wr_lane_i(rc_lane), .wdata_i(bus_wdata), .flags_o(rc_q));

  can_rxf_bank #(.NB(NB), .BW(BW)) u_rt_bank (
    .clk(clk), .rst_n(rst_n), .set_i(rem_vec), .hclr_i(dat_vec | tx_vec),
    .wr_lane_i(rt_lane), .wdata_i(bus_wdata), .flags_o(rt_q));

  assign rx_irq = |(rc_q & rx_irq_en);
endmodule

// File: rtl/can_rx_flags_chk.sv
module can_rx_flags_chk #(
  parameter int NB = 16,
  parameter int BW = 8,
  parameter int AW = 8,
  parameter int IW = 4,
  parameter logic [AW-1:0] BASE = 8'h48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_done,
  input logic [IW-1:0] rx_buf,
  input logic          rx_remote,
  input logic          tx_done,
  input logic [IW-1:0] tx_buf,
  input logic [NB-1:0] rx_irq_en,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_rmw,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] bus_wdata,
  input logic [BW-1:0] bus_rdata,
  input logic          rx_irq,
  input logic [NB-1:0] rc_q,
  input logic [NB-1:0] rt_q
);
  logic in_map;
  assign in_map = (bus_addr >= BASE) && (bus_addr < BASE + AW'(4));

  p_rx_sets_rc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rc_q[$past(rx_buf)]);

  p_irq_has_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (|(rc_q & rx_irq_en)));

  p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_en == '0) |-> !rx_irq);

  p_w1_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == BASE && bus_wdata == '1)
      |=> rc_q[BW-1:0] == $past(rc_q[BW-1:0]));

  p_remote_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_remote) |=> rt_q[$past(rx_buf)] && rc_q[$past(rx_buf)]);

  p_data_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_remote) |=> !rt_q[$past(rx_buf)]);

  p_tx_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !(rx_done && rx_remote && rx_buf == tx_buf))
      |=> !rt_q[$past(tx_buf)]);

  p_rmw_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_rmw && in_map) |-> bus_rdata == '1);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !in_map) |-> bus_rdata == '0);
endmodule

bind can_rx_flags can_rx_flags_chk #(
  .NB(NB), .BW(BW), .AW(AW), .IW(IW), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_buf(rx_buf),
  .rx_remote(rx_remote), .tx_done(tx_done), .tx_buf(tx_buf),
  .rx_irq_en(rx_irq_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .rx_irq(rx_irq), .rc_q(rc_q), .rt_q(rt_q)
);

// File: tb/tb_can_rx_flags.sv
`timescale 1ns/1ps
module tb_can_rx_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_done = 0, rx_remote = 0, tx_done = 0;
  logic [3:0]  rx_buf = 0, tx_buf = 0;
  logic [15:0] rx_irq_en = 0;
  logic        bus_sel = 0, bus_wr = 0, bus_rmw = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        rx_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_rx_flags dut (.*);

  typedef struct packed {
    logic rxv; logic [3:0] rxb; logic rem;
    logic txv; logic [3:0] txb;
    logic wr; logic [7:0] addr; logic [7:0] wd;
    logic [15:0] erc; logic [15:0] ert;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1,4'd3, 1'b0,1'b0,4'd0, 1'b0,8'h00,8'h00,16'h0008,16'h0000}, // R1
    '{1'b1,4'd10,1'b1,1'b0,4'd0, 1'b0,8'h00,8'h00,16'h0408,16'h0400}, // R5
    '{1'b1,4'd10,1'b0,1'b0,4'd0, 1'b0,8'h00,8'h00,16'h0408,16'h0000}, // R6
    '{1'b1,4'd5, 1'b1,1'b0,4'd0, 1'b0,8'h00,8'h00,16'h0428,16'h0020}, // R5
    '{1'b0,4'd0, 1'b0,1'b1,4'd5, 1'b0,8'h00,8'h00,16'h0428,16'h0000}, // R7
    '{1'b1,4'd12,1'b1,1'b1,4'd12,1'b0,8'h00,8'h00,16'h1428,16'h1000}, // R7 set wins
    '{1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,8'h48,8'hF7,16'h1420,16'h1000}, // R3
    '{1'b1,4'd1, 1'b0,1'b0,4'd0, 1'b1,8'h49,8'h00,16'h0022,16'h1000}, // R11
    '{1'b1,4'd5, 1'b0,1'b0,4'd0, 1'b1,8'h48,8'h00,16'h0020,16'h1000}, // R4
    '{1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,8'h4B,8'hFF,16'h0020,16'h1000}, // R3
    '{1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,8'h4B,8'hEF,16'h0020,16'h0000}, // R3
    '{1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,8'h4C,8'h00,16'h0020,16'h0000}, // R10
    '{1'b1,4'd15,1'b1,1'b0,4'd0, 1'b1,8'h4B,8'h00,16'h8020,16'h8000}, // R4
    '{1'b0,4'd0, 1'b0,1'b0,4'd0, 1'b1,8'h4A,8'h00,16'h8020,16'h8000}  // R11
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic rmw, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_rmw = rmw; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0; bus_rmw = 0;
  endtask

  task automatic rd16(input logic [7:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, 1'b0, lo);
    rd(a + 8'd1, 1'b0, hi);
    v = {hi, lo};
  endtask

  task automatic wr8(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] rc, rt;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    rd16(8'h48, rc); check("R9 rc after reset", rc, 16'h0000);
    rd16(8'h4A, rt); check("R9 rt after reset", rt, 16'h0000);
    check("R9 irq after reset", {15'd0, rx_irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rx_done = VECS[i].rxv; rx_buf = VECS[i].rxb; rx_remote = VECS[i].rem;
      tx_done = VECS[i].txv; tx_buf = VECS[i].txb;
      bus_sel = VECS[i].wr; bus_wr = VECS[i].wr;
      bus_addr = VECS[i].addr; bus_wdata = VECS[i].wd;
      @(negedge clk);
      rx_done = 0; tx_done = 0; bus_sel = 0; bus_wr = 0;
      rd16(8'h48, rc); check($sformatf("vec %0d rc (R1 R3 R4 R5 R6 R11)", i), rc, VECS[i].erc);
      rd16(8'h4A, rt); check($sformatf("vec %0d rt (R5 R6 R7 R10)", i), rt, VECS[i].ert);
    end

    // R10 unmapped read returns zero
    rd(8'h47, 1'b0, b); check("R10 read below map", {8'd0, b}, 16'h0000);
    rd(8'h4C, 1'b0, b); check("R10 read above map", {8'd0, b}, 16'h0000);

    // R2 interrupt masking, state rc=8020
    @(negedge clk); rx_irq_en = 16'h0000; #1;
    check("R2 irq mask zero", {15'd0, rx_irq}, 16'h0000);
    @(negedge clk); rx_irq_en = 16'h0001; #1;
    check("R2 irq mask on idle bit", {15'd0, rx_irq}, 16'h0000);
    @(negedge clk); rx_irq_en = 16'h0020; #1;
    check("R2 irq mask on pending bit", {15'd0, rx_irq}, 16'h0001);

    // R8 read-modify-write returns ones, write-back keeps flags
    rd(8'h48, 1'b1, b); check("R8 rmw read rc low", {8'd0, b}, 16'h00FF);
    rd(8'h4B, 1'b1, b); check("R8 rmw read rt high", {8'd0, b}, 16'h00FF);
    rd(8'h48, 1'b0, b); check("R8 normal read rc low", {8'd0, b}, 16'h0020);
    wr8(8'h48, 8'hFF);
    rd16(8'h48, rc); check("R8 write-back keeps rc", rc, 16'h8020);
    check("R2 irq still pending", {15'd0, rx_irq}, 16'h0001);

    // R2 clearing the enabled flag drops the interrupt
    wr8(8'h48, 8'hDF); #1;
    check("R2 irq drops after clear", {15'd0, rx_irq}, 16'h0000);
    rd16(8'h48, rc); check("R3 cleared bit five", rc, 16'h8000);

    // R9 reset in mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd16(8'h48, rc); check("R9 rc after second reset", rc, 16'h0000);
    rd16(8'h4A, rt); check("R9 rt after second reset", rt, 16'h0000);

    finish_run();
  end
endmodule